// File: doc/BRIEF.md
# Dual-Enable Byte-Lane Static RAM

This block stands in for a 16-bit asynchronous static RAM inside a synchronous design. It decodes the device-side pins of such a part: a low-true chip enable, a high-true chip enable, an output enable, a write enable and a select for each of the two byte lanes. All of these pins are sampled on the system clock. A write updates only the lanes whose select is low. A read drives only the lanes whose select is low. The tri-state data bus is split into a read-data word and a per-lane drive-enable vector, so that a surrounding level can build its own bus buffers.

The block is selected only when both chip enables are active and at least one lane select is low. In every other case it reports standby and drives nothing. The write enable always overrides the output enable: while a write is requested, no lane is ever driven. The array contents are not reset. The depth is 2^ADDR_W words. ADDR_W = 18 gives the full 262,144-word array, and the default is kept small for elaboration.

Top module: `sram_lane_array`

## Requirements
- R1: The block is selected only when chipSelN is 0, chipSelHi is 1, and at least one of loSelN and hiSelN is 0. The standby output is 1 in the cycle after any edge where the block was not selected, and 0 in the cycle after any edge where it was selected.
- R2: While rstN is low, laneOe is 00, rdData is 0 and standby is 1. The array contents are not cleared.
- R3: When the block is selected with wrEnN = 1 and outEnN = 1, laneOe becomes 00 and rdData becomes 0 one cycle later.
- R4: A read is sampled at an edge where the block is selected, wrEnN = 1 and outEnN = 0. One cycle later, laneOe[0] equals the inverse of loSelN and laneOe[1] equals the inverse of hiSelN. rdData bits 7:0 carry the stored lower lane, and bits 15:8 carry the stored upper lane. Any lane whose select is high reads as zero.
- R5: A write takes effect at an edge where the block is selected and wrEnN = 0. It stores wrData[7:0] when loSelN = 0 and wrData[15:8] when hiSelN = 0. Any lane whose select is high keeps its previous content. The new data is readable at the very next edge.
- R6: After any edge with wrEnN = 0, laneOe is 00 and rdData is 0, whatever the value of outEnN.
- R7: A write request (wrEnN = 0) made while the block is not selected leaves every lane of the addressed word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every pin is sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the output registers |
| chipSelN | input | 1 | Chip enable, active low |
| chipSelHi | input | 1 | Chip enable, active high |
| outEnN | input | 1 | Output enable, active low |
| wrEnN | input | 1 | Write enable, active low |
| loSelN | input | 1 | Lower byte lane (bits 7:0) select, active low |
| hiSelN | input | 1 | Upper byte lane (bits 15:8) select, active low |
| addr | input | ADDR_W | Word address |
| wrData | input | 2*LANE_W | Write data |
| rdData | output | 2*LANE_W | Read data, zero in any lane not driven |
| laneOe | output | 2 | Per-lane drive enable for external bus buffers |
| standby | output | 1 | 1 when the block was not selected at the last edge |

## Verification
The write enable and the output enable can both be active at the same edge. In that case the block must carry out the write and still keep every lane quiet. The bench provokes this by walking all 64 combinations of the six control pins at many addresses. It compares laneOe, rdData and standby against values computed from the pin levels alone. After each combination, a full-word read of the same address shows whether the write landed in exactly the selected lanes, or, when the block was not selected, landed nowhere.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  localparam int NUM_LANES = 2;

  typedef struct packed {
    logic                 selected;
    logic [NUM_LANES-1:0] wrLane;
    logic [NUM_LANES-1:0] rdLane;
  } laneStrobes_t;
endpackage

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
(
  input  logic                 chipSelN,
  input  logic                 chipSelHi,
  input  logic                 outEnN,
  input  logic                 wrEnN,
  input  logic [NUM_LANES-1:0] laneSelN,
  output laneStrobes_t         strobes
);
  logic chipOn;
  logic anyLane;
  logic selected;
  logic doWrite;
  logic doRead;

  always_comb begin
    chipOn   = !chipSelN && chipSelHi;
    anyLane  = !(&laneSelN);
    selected = chipOn && anyLane;
    // A write request always wins over output drive.
    doWrite  = selected && !wrEnN;
    doRead   = selected && wrEnN && !outEnN;
  end

  assign strobes.selected = selected;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign strobes.wrLane[g] = doWrite && !laneSelN[g];
    assign strobes.rdLane[g] = doRead && !laneSelN[g];
  end
endmodule

// File: rtl/sram_lane_datapath.sv
module sram_lane_datapath
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  laneStrobes_t                strobes,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM_LANES*LANE_W-1:0] wrData,
  output logic [NUM_LANES*LANE_W-1:0] rdData,
  output logic [NUM_LANES-1:0]        laneOe,
  output logic                        standby
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] rdReg;
    logic              oeReg;

    // Array contents are never reset.
    always_ff @(posedge clk) begin
      if (strobes.wrLane[g]) store[addr] <= wrData[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdReg <= '0;
        oeReg <= 1'b0;
      end else begin
        rdReg <= strobes.rdLane[g] ? store[addr] : '0;
        oeReg <= strobes.rdLane[g];
      end
    end

    assign rdData[g*LANE_W +: LANE_W] = rdReg;
    assign laneOe[g] = oeReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) standby <= 1'b1;
    else       standby <= !strobes.selected;
  end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        chipSelN,
  input  logic                        chipSelHi,
  input  logic                        outEnN,
  input  logic                        wrEnN,
  input  logic                        loSelN,
  input  logic                        hiSelN,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM_LANES*LANE_W-1:0] wrData,
  output logic [NUM_LANES*LANE_W-1:0] rdData,
  output logic [NUM_LANES-1:0]        laneOe,
  output logic                        standby
);
  laneStrobes_t strobes;

  sram_lane_ctrl u_ctrl (
    .chipSelN (chipSelN),
    .chipSelHi(chipSelHi),
    .outEnN   (outEnN),
    .wrEnN    (wrEnN),
    .laneSelN ({hiSelN, loSelN}),
    .strobes  (strobes)
  );

  sram_lane_datapath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .laneOe (laneOe),
    .standby(standby)
  );
endmodule

// File: rtl/sram_lane_array_chk.sv
module sram_lane_array_chk #(
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                chipSelN,
  input logic                chipSelHi,
  input logic                outEnN,
  input logic                wrEnN,
  input logic                loSelN,
  input logic                hiSelN,
  input logic [2*LANE_W-1:0] rdData,
  input logic [1:0]          laneOe,
  input logic                standby
);
  a_r1_standby_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (chipSelN || !chipSelHi || (loSelN && hiSelN)) |=> standby);

  a_r1_active_when_on: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSelN && chipSelHi && !(loSelN && hiSelN)) |=> !standby);

  a_r3_output_disable: assert property (@(posedge clk) disable iff (!rstN)
    (wrEnN && outEnN) |=> (laneOe == 2'b00));

  a_r6_no_drive_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !wrEnN |=> (laneOe == 2'b00));

  a_r4_lo_mask: assert property (@(posedge clk) disable iff (!rstN)
    laneOe[0] |-> !$past(loSelN));

  a_r4_hi_mask: assert property (@(posedge clk) disable iff (!rstN)
    laneOe[1] |-> !$past(hiSelN));

  a_r4_quiet_lo: assert property (@(posedge clk) disable iff (!rstN)
    !laneOe[0] |-> (rdData[LANE_W-1:0] == '0));

  a_r4_quiet_hi: assert property (@(posedge clk) disable iff (!rstN)
    !laneOe[1] |-> (rdData[2*LANE_W-1:LANE_W] == '0));
endmodule

bind sram_lane_array sram_lane_array_chk #(.LANE_W(LANE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .chipSelN (chipSelN),
  .chipSelHi(chipSelHi),
  .outEnN   (outEnN),
  .wrEnN    (wrEnN),
  .loSelN   (loSelN),
  .hiSelN   (hiSelN),
  .rdData   (rdData),
  .laneOe   (laneOe),
  .standby  (standby)
);

// File: tb/sram_lane_array_bench.sv
`timescale 1ns/1ps
module sram_lane_array_bench;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SWEEP  = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSelN = 1'b1, chipSelHi = 1'b0, outEnN = 1'b1, wrEnN = 1'b1;
  logic loSelN = 1'b1, hiSelN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0]  laneOe;
  logic        standby;

  int tests = 0;
  int fails = 0;
  logic [15:0] model [DEPTH];

  always #5 clk = ~clk;

  sram_lane_array #(.ADDR_W(ADDR_W), .LANE_W(8)) u_sram_lane_array (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .chipSelHi(chipSelHi),
    .outEnN(outEnN), .wrEnN(wrEnN), .loSelN(loSelN), .hiSelN(hiSelN),
    .addr(addr), .wrData(wrData), .rdData(rdData), .laneOe(laneOe),
    .standby(standby)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clocked access: drive just after an edge, sample just after the next.
  task automatic access(input logic [5:0] pins, input logic [ADDR_W-1:0] a,
                        input logic [15:0] d);
    logic sel, rd;
    logic [1:0] exOe;
    logic [15:0] exData;
    string tag;
    {hiSelN, loSelN, wrEnN, outEnN, chipSelHi, chipSelN} = pins;
    addr = a;
    wrData = d;
    sel = !pins[0] && pins[1] && !(pins[4] && pins[5]);
    rd  = sel && pins[3] && !pins[2];
    exOe = {rd && !pins[5], rd && !pins[4]};
    exData = {exOe[1] ? model[a][15:8] : 8'h00, exOe[0] ? model[a][7:0] : 8'h00};
    if (!pins[3])               tag = "R6";
    else if (sel && pins[2])    tag = "R3";
    else                        tag = "R4";
    @(posedge clk);
    #1;
    chk("R1", {31'd0, standby}, {31'd0, !sel});
    chk(tag, {30'd0, laneOe}, {30'd0, exOe});
    chk(tag, {16'd0, rdData}, {16'd0, exData});
    if (sel && !pins[3]) begin
      if (!pins[4]) model[a][7:0]  = d[7:0];
      if (!pins[5]) model[a][15:8] = d[15:8];
    end
  endtask

  // Full-word read right after a pattern, judged against the model.
  task automatic readBack(input logic [ADDR_W-1:0] a, input string req);
    {hiSelN, loSelN, wrEnN, outEnN, chipSelHi, chipSelN} = 6'b001010;
    addr = a;
    @(posedge clk);
    #1;
    chk(req, {30'd0, laneOe}, 32'd3);
    chk(req, {16'd0, rdData}, {16'd0, model[a]});
  endtask

  initial begin
    #200_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R2", {30'd0, laneOe}, 32'd0);
    chk("R2", {16'd0, rdData}, 32'd0);
    chk("R2", {31'd0, standby}, 32'd1);
    rstN = 1'b1;

    // Fill the swept addresses with full-word writes.
    for (int a = 0; a < SWEEP; a++) begin
      access(6'b000010, a[ADDR_W-1:0], 16'hA500 ^ 16'(a * 16'h0137));
    end
    for (int a = 0; a < SWEEP; a++) readBack(a[ADDR_W-1:0], "R5");

    // Every pin combination at every swept address, each followed by a read.
    for (int a = 0; a < SWEEP; a++) begin
      for (int p = 0; p < 64; p++) begin
        logic [5:0] pins;
        logic sel;
        logic [15:0] d;
        pins = p[5:0];
        sel = !pins[0] && pins[1] && !(pins[4] && pins[5]);
        d = 16'((a * 16'h2F1B) ^ (p * 16'h0841) ^ 16'h5AC3);
        access(pins, a[ADDR_W-1:0], d);
        if (!pins[3]) readBack(a[ADDR_W-1:0], sel ? "R5" : "R7");
        else          readBack(a[ADDR_W-1:0], "R4");
      end
    end

    // Write with output enable active at the top address, then read it back.
    access(6'b000010, ADDR_W'(DEPTH - 1), 16'hBEEF);
    readBack(ADDR_W'(DEPTH - 1), "R5");
    access(6'b010010, ADDR_W'(DEPTH - 1), 16'h1234);
    readBack(ADDR_W'(DEPTH - 1), "R5");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule